// File: doc/BRIEF.md
# Card-to-host stream packet source

This block turns packet requests into beats on a card-to-host stream with valid/ready handshaking. A request names a byte length, a queue number, a port number, a completion flag and a marker flag. Once a request is taken, the block reads the payload one beat at a time from a combinational byte source. It presents each beat on the stream together with a CRC-32 computed over that beat. The block accepts one packet at a time, and a new request is taken only after the final beat of the previous packet has been accepted downstream.

The control sideband (length, queue, port, flags and a 7-bit single-error-correct, double-error-detect code over a packed control word) is valid from the first beat and is held for the whole packet. The final beat reports how many bytes at its top are unused. Requests longer than 31 host buffers are refused with a one-cycle error pulse and produce no beats. A zero-length request still produces a single beat.

Top module: `c2h_pkt_source`

## Requirements
- R1: The bus width DATA_W is one of 64, 128, 256 or 512 bits, giving BYTES = DATA_W/8. A packet of len bytes is sent as ceil(len/BYTES) beats, with a minimum of one beat, and m_tlast is high on exactly the final beat.
- R2: req_ready is high exactly when no packet is in progress. It falls in the cycle after a request is taken and rises in the cycle after the beat with m_tlast is accepted. m_tvalid is low whenever req_ready is high.
- R3: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata, m_tcrc, m_tlast and m_mty keep their values into the next cycle.
- R4: m_len, m_qid, m_port, m_cmpt, m_marker and m_ecc equal the values of the accepted request on every beat of its packet, starting with the first, and do not change while req_ready is low.
- R5: A request with len = 0 produces exactly one beat with m_tlast = 1, m_mty = 0, m_tdata = 0 and m_tcrc = 0, and it never raises fetch_en.
- R6: On the final beat of a packet with len > 0, m_mty = BYTES*beats - len. On every other beat m_mty = 0. Bytes above the last valid byte of the final beat are driven as zero.
- R7: m_tcrc is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, result inverted) over the beat's valid bytes, taken in the order byte 0 (m_tdata[7:0]) upward.
- R8: A request with len greater than 31*HOST_BUF_BYTES is taken (req_ready high) but refused. req_err is high for the one cycle after the handshake and at no other time, no beat is sent, and req_ready stays high.
- R9: m_ecc is computed over the 57-bit word {24'h0, cmpt, marker, port[2:0], qid[11:0], len[15:0]}, whose bit 0 is len[0]. The word bits fill, in ascending order, codeword positions 1..63 that are not powers of two. m_ecc[k] for k = 0..5 is the XOR of the codeword positions whose index has bit k set. m_ecc[6] is the XOR of all 57 word bits and the six check bits.
- R10: Beat i of a packet with len > 0 is loaded from fetch_data in the cycle where fetch_en is high and fetch_idx = i. Byte b of that beat sits at m_tdata[8b+7:8b], and m_tvalid is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_len | input | 16 | Packet length in bytes |
| req_qid | input | 12 | Queue number |
| req_port | input | 3 | Port number |
| req_cmpt | input | 1 | Packet has a completion |
| req_marker | input | 1 | Packet is a flush marker |
| req_err | output | 1 | One-cycle pulse: request refused as too long |
| fetch_en | output | 1 | Payload beat is being read this cycle |
| fetch_idx | output | 16 | Beat index within the packet being read |
| fetch_data | input | DATA_W | Payload bytes for beat fetch_idx |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | DATA_W | Beat payload |
| m_tcrc | output | 32 | CRC-32 of this beat |
| m_tlast | output | 1 | Final beat of packet |
| m_mty | output | 6 | Unused top bytes on the final beat |
| m_len | output | 16 | Packet length sideband |
| m_qid | output | 12 | Queue number sideband |
| m_port | output | 3 | Port number sideband |
| m_cmpt | output | 1 | Completion flag sideband |
| m_marker | output | 1 | Marker flag sideband |
| m_ecc | output | 7 | Check code over the packed control word |

## Verification
The bench sends lengths of zero, one byte, a partial second beat, exact multiples of the beat width, exactly the length limit and one byte over it. A wrong ceiling or off-by-one beat count shows up as a misplaced m_tlast or a leftover expected beat. A wrong empty count or unmasked tail bytes show up as a mismatch in m_mty, m_tdata or m_tcrc, because the byte source returns non-zero bytes past the packet end. Pseudo-random sink stalls catch beats that change or vanish under backpressure. Back-to-back requests held high while busy catch a design that takes a second packet early. Control words with differing flags, queues and ports catch a mispacked or misordered check-code word.

// File: rtl/pktsrc_pkg.sv
`timescale 1ns/1ps
package pktsrc_pkg;

  localparam int LEN_W    = 16;
  localparam int QID_W    = 12;
  localparam int PORT_W   = 3;
  localparam int MTY_W    = 6;
  localparam int ECC_W    = 7;
  localparam int WORD_W   = 57;
  localparam int CRC_W    = 32;
  localparam int MAX_BYTES = 64;
  localparam int MAX_W    = MAX_BYTES * 8;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [QID_W-1:0]  qid;
    logic [PORT_W-1:0] port;
    logic              cmpt;
    logic              marker;
  } pkt_ctrl_t;

  // Fixed-order control word, most significant field first.
  function automatic logic [WORD_W-1:0] ctrl_word(input pkt_ctrl_t c);
    return {24'h000000, c.cmpt, c.marker, c.port, c.qid, c.len};
  endfunction

  // Hamming code over 63 positions plus an overall parity bit.
  function automatic logic [ECC_W-1:0] secded_code(input logic [WORD_W-1:0] w);
    logic [63:0]       cw;
    logic [WORD_W-1:0] ws;
    logic [63:0]       cs;
    logic [5:0]        chk;
    cw  = '0;
    ws  = w;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw = cw | (64'(ws[0]) << p);
        ws = ws >> 1;
      end
    end
    chk = '0;
    cs  = cw;
    for (int p = 0; p < 64; p++) begin
      if (cs[0]) chk = chk ^ 6'(p);
      cs = cs >> 1;
    end
    return {(^cw) ^ (^chk), chk};
  endfunction

  // Reflected CRC-32 over the first nbytes bytes, byte 0 at the bottom.
  function automatic logic [CRC_W-1:0] crc32_beat(input logic [MAX_W-1:0] d,
                                                  input logic [6:0] nbytes);
    logic [CRC_W-1:0] r;
    logic [7:0]       byt;
    r = '1;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (7'(i) < nbytes) begin
        byt = 8'(d >> (8 * i));
        for (int j = 0; j < 8; j++) begin
          if (r[0] ^ byt[0]) r = (r >> 1) ^ CRC_POLY_REFL;
          else               r = r >> 1;
          byt = byt >> 1;
        end
      end
    end
    return ~r;
  endfunction

  // Beats needed for len bytes at 2**bsh bytes per beat, at least one.
  function automatic logic [16:0] beats_needed(input logic [LEN_W-1:0] len,
                                               input int unsigned bsh);
    logic [16:0] s;
    if (len == '0) return 17'd1;
    s = {1'b0, len} + ((17'd1 << bsh) - 17'd1);
    return s >> bsh;
  endfunction

endpackage

// File: rtl/pktsrc_req_gate.sv
`timescale 1ns/1ps
module pktsrc_req_gate
  import pktsrc_pkg::*;
#(
  parameter int          BSH   = 3,
  parameter logic [15:0] LIMIT = 16'd15872
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [QID_W-1:0] req_qid,
  input  logic [PORT_W-1:0] req_port,
  input  logic             req_cmpt,
  input  logic             req_marker,
  input  logic             busy,
  output logic             req_ready,
  output logic             pkt_accept,
  output logic             pkt_reject,
  output logic             req_err,
  output pkt_ctrl_t        ctrl_q,
  output logic [16:0]      nbeats_q
);

  logic too_long;
  logic take;

  assign too_long   = req_len > LIMIT;
  assign req_ready  = !busy;
  assign take       = req_valid && req_ready;
  assign pkt_accept = take && !too_long;
  assign pkt_reject = take && too_long;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_err  <= 1'b0;
      ctrl_q   <= '0;
      nbeats_q <= '0;
    end else begin
      req_err <= pkt_reject;
      if (pkt_accept) begin
        ctrl_q.len    <= req_len;
        ctrl_q.qid    <= req_qid;
        ctrl_q.port   <= req_port;
        ctrl_q.cmpt   <= req_cmpt;
        ctrl_q.marker <= req_marker;
        nbeats_q      <= beats_needed(req_len, BSH);
      end
    end
  end

endmodule

// File: rtl/pktsrc_beat_build.sv
`timescale 1ns/1ps
module pktsrc_beat_build
  import pktsrc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [16:0]       idx,
  input  logic [16:0]       nbeats,
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] data_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic              last_o,
  output logic [MTY_W-1:0]  mty_o
);

  localparam int BYTES = DATA_W / 8;
  localparam int BSH   = $clog2(BYTES);

  logic [16:0]      base;
  logic [16:0]      rem;
  logic [6:0]       nvalid;
  logic [MAX_W-1:0] wide;

  always_comb begin
    last_o = (idx + 17'd1) == nbeats;
    base   = idx << BSH;
    rem    = {1'b0, len} - base;
    if (len == '0)                 nvalid = 7'd0;
    else if (rem >= 17'(BYTES))    nvalid = 7'(BYTES);
    else                           nvalid = rem[6:0];
    mty_o = (last_o && len != '0) ? 6'(7'(BYTES) - nvalid) : 6'd0;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte_mask
    assign data_o[8*b +: 8] = (7'(b) < nvalid) ? raw[8*b +: 8] : 8'h00;
  end

  always_comb begin
    wide               = '0;
    wide[DATA_W-1:0]   = data_o;
    crc_o              = crc32_beat(wide, nvalid);
  end

endmodule

// File: rtl/pktsrc_ctrl_ecc.sv
`timescale 1ns/1ps
module pktsrc_ctrl_ecc
  import pktsrc_pkg::*;
(
  input  pkt_ctrl_t        ctrl,
  output logic [ECC_W-1:0] ecc
);

  logic [WORD_W-1:0] word;

  assign word = ctrl_word(ctrl);
  assign ecc  = secded_code(word);

endmodule

// File: rtl/c2h_pkt_source.sv
`timescale 1ns/1ps
module c2h_pkt_source
  import pktsrc_pkg::*;
#(
  parameter int DATA_W         = 64,
  parameter int HOST_BUF_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_len,
  input  logic [11:0]       req_qid,
  input  logic [2:0]        req_port,
  input  logic              req_cmpt,
  input  logic              req_marker,
  output logic              req_err,
  output logic              fetch_en,
  output logic [15:0]       fetch_idx,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [31:0]       m_tcrc,
  output logic              m_tlast,
  output logic [5:0]        m_mty,
  output logic [15:0]       m_len,
  output logic [11:0]       m_qid,
  output logic [2:0]        m_port,
  output logic              m_cmpt,
  output logic              m_marker,
  output logic [6:0]        m_ecc
);

  localparam int BYTES       = DATA_W / 8;
  localparam int BSH         = $clog2(BYTES);
  localparam int LEN_LIMIT   = 31 * HOST_BUF_BYTES;
  localparam int LIMIT_CLAMP = (LEN_LIMIT > 65535) ? 65535 : LEN_LIMIT;
  localparam logic [15:0] LIMIT_W = LIMIT_CLAMP[15:0];

  // Named internal events
  logic        pkt_accept;
  logic        pkt_reject;
  logic        busy_q;
  logic [16:0] idx_q;
  logic [16:0] nbeats_q;
  logic        more_beats;
  logic        out_free;
  logic        fetch_go;
  logic        beat_taken;
  logic        last_taken;
  pkt_ctrl_t   ctrl_q;

  logic [DATA_W-1:0] bb_data;
  logic [CRC_W-1:0]  bb_crc;
  logic              bb_last;
  logic [MTY_W-1:0]  bb_mty;

  pktsrc_req_gate #(
    .BSH   (BSH),
    .LIMIT (LIMIT_W)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .req_qid    (req_qid),
    .req_port   (req_port),
    .req_cmpt   (req_cmpt),
    .req_marker (req_marker),
    .busy       (busy_q),
    .req_ready  (req_ready),
    .pkt_accept (pkt_accept),
    .pkt_reject (pkt_reject),
    .req_err    (req_err),
    .ctrl_q     (ctrl_q),
    .nbeats_q   (nbeats_q)
  );

  pktsrc_beat_build #(
    .DATA_W (DATA_W)
  ) u_beat (
    .raw    (fetch_data),
    .idx    (idx_q),
    .nbeats (nbeats_q),
    .len    (ctrl_q.len),
    .data_o (bb_data),
    .crc_o  (bb_crc),
    .last_o (bb_last),
    .mty_o  (bb_mty)
  );

  pktsrc_ctrl_ecc u_ecc (
    .ctrl (ctrl_q),
    .ecc  (m_ecc)
  );

  assign more_beats = idx_q < nbeats_q;
  assign out_free   = !m_tvalid || m_tready;
  assign fetch_go   = busy_q && more_beats && out_free;
  assign beat_taken = m_tvalid && m_tready;
  assign last_taken = beat_taken && m_tlast;

  assign fetch_en  = fetch_go && (ctrl_q.len != 16'd0);
  assign fetch_idx = idx_q[15:0];

  assign m_len    = ctrl_q.len;
  assign m_qid    = ctrl_q.qid;
  assign m_port   = ctrl_q.port;
  assign m_cmpt   = ctrl_q.cmpt;
  assign m_marker = ctrl_q.marker;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tcrc   <= '0;
      m_tlast  <= 1'b0;
      m_mty    <= '0;
    end else begin
      if (pkt_accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else begin
        if (last_taken) busy_q <= 1'b0;
        if (fetch_go)   idx_q  <= idx_q + 17'd1;
      end
      if (fetch_go) begin
        m_tvalid <= 1'b1;
        m_tdata  <= bb_data;
        m_tcrc   <= bb_crc;
        m_tlast  <= bb_last;
        m_mty    <= bb_mty;
      end else if (beat_taken) begin
        m_tvalid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pktsrc_checker.sv
`timescale 1ns/1ps
module pktsrc_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_err,
  input logic              pkt_accept,
  input logic              pkt_reject,
  input logic              fetch_en,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic [31:0]       m_tcrc,
  input logic              m_tlast,
  input logic [5:0]        m_mty,
  input logic [15:0]       m_len,
  input logic [11:0]       m_qid,
  input logic [2:0]        m_port,
  input logic              m_cmpt,
  input logic              m_marker,
  input logic [6:0]        m_ecc
);

  assert_hold_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tcrc)
                              && $stable(m_tlast) && $stable(m_mty));

  assert_idle_no_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !m_tvalid);

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_accept |=> !req_ready);

  assert_last_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> req_ready);

  assert_ctrl_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(m_len) && $stable(m_qid) && $stable(m_port)
                   && $stable(m_cmpt) && $stable(m_marker) && $stable(m_ecc));

  assert_zero_len_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_len == 16'd0 |-> m_tlast && m_mty == 6'd0 && m_tcrc == 32'd0);

  assert_zero_len_no_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> m_len != 16'd0);

  assert_mty_only_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> m_mty == 6'd0);

  assert_reject_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_reject |=> req_ready && req_err && !m_tvalid);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !req_err);

  assert_fetch_shows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> m_tvalid);

endmodule

bind c2h_pkt_source pktsrc_checker #(.DATA_W(DATA_W)) u_pktsrc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .req_err    (req_err),
  .pkt_accept (pkt_accept),
  .pkt_reject (pkt_reject),
  .fetch_en   (fetch_en),
  .m_tvalid   (m_tvalid),
  .m_tready   (m_tready),
  .m_tdata    (m_tdata),
  .m_tcrc     (m_tcrc),
  .m_tlast    (m_tlast),
  .m_mty      (m_mty),
  .m_len      (m_len),
  .m_qid      (m_qid),
  .m_port     (m_port),
  .m_cmpt     (m_cmpt),
  .m_marker   (m_marker),
  .m_ecc      (m_ecc)
);

// File: tb/tb_c2h_pkt_source.sv
`timescale 1ns/1ps
module tb_c2h_pkt_source;

  localparam int DW    = 64;
  localparam int BY    = DW / 8;
  localparam int HBUF  = 512;
  localparam int LIMIT = 31 * HBUF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid, req_ready, req_cmpt, req_marker, req_err;
  logic [15:0]   req_len;
  logic [11:0]   req_qid;
  logic [2:0]    req_port;
  logic          fetch_en;
  logic [15:0]   fetch_idx;
  logic [DW-1:0] fetch_data;
  logic          m_tvalid, m_tready, m_tlast, m_cmpt, m_marker;
  logic [DW-1:0] m_tdata;
  logic [31:0]   m_tcrc;
  logic [5:0]    m_mty;
  logic [15:0]   m_len;
  logic [11:0]   m_qid;
  logic [2:0]    m_port;
  logic [6:0]    m_ecc;

  c2h_pkt_source #(.DATA_W(DW), .HOST_BUF_BYTES(HBUF)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .req_qid(req_qid), .req_port(req_port), .req_cmpt(req_cmpt),
    .req_marker(req_marker), .req_err(req_err),
    .fetch_en(fetch_en), .fetch_idx(fetch_idx), .fetch_data(fetch_data),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tcrc(m_tcrc), .m_tlast(m_tlast), .m_mty(m_mty), .m_len(m_len),
    .m_qid(m_qid), .m_port(m_port), .m_cmpt(m_cmpt), .m_marker(m_marker),
    .m_ecc(m_ecc)
  );

  typedef struct packed {
    logic [DW-1:0] data;
    logic [31:0]   crc;
    logic          last;
    logic [5:0]    mty;
  } beat_t;

  beat_t       exp_q[$];
  beat_t       prev_beat;
  bit          prev_stall = 0;
  bit          err_due = 0;
  bit          ready_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          errors = 0, checks = 0, cycles = 0, cur_pkt = 0;
  logic [15:0] e_len;
  logic [11:0] e_qid;
  logic [2:0]  e_port;
  logic        e_cmpt, e_marker;
  logic [6:0]  e_ecc;

  function automatic logic [7:0] src_byte(input int pkt, input int k);
    return 8'(pkt * 29 + k * 13 + (k >> 8) + 1);
  endfunction

  always_comb begin
    for (int b = 0; b < BY; b++)
      fetch_data[8*b +: 8] = src_byte(cur_pkt, int'(fetch_idx) * BY + b);
  end

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int j = 0; j < 8; j++)
      r = (r >> 1) ^ ({32{r[0] ^ d[j]}} & 32'hEDB88320);
    return r;
  endfunction

  function automatic logic [6:0] ecc_ref(input logic [56:0] w);
    logic [63:0] cw;
    logic [5:0]  c;
    int          k;
    cw = '0;
    k = 0;
    for (int p = 1; p < 64; p++)
      if ((p & (p - 1)) != 0) begin cw[p] = w[k]; k++; end
    for (int i = 0; i < 6; i++) begin
      c[i] = 1'b0;
      for (int p = 1; p < 64; p++)
        if ((p & (1 << i)) != 0) c[i] = c[i] ^ cw[p];
    end
    for (int i = 0; i < 6; i++) cw[1 << i] = c[i];
    return {^cw, c};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_pkt(input int len);
    int nb;
    nb = (len == 0) ? 1 : (len + BY - 1) / BY;
    for (int i = 0; i < nb; i++) begin
      beat_t       bt;
      logic [31:0] c;
      int          nv;
      c = '1;
      bt.data = '0;
      nv = 0;
      for (int b = 0; b < BY; b++) begin
        if (i * BY + b < len) begin
          bt.data[8*b +: 8] = src_byte(cur_pkt, i * BY + b);
          nv++;
        end
      end
      for (int b = 0; b < nv; b++) c = crc_byte(c, bt.data[8*b +: 8]);
      bt.crc  = ~c;
      bt.last = (i == nb - 1);
      bt.mty  = (bt.last && len > 0) ? 6'(nb * BY - len) : 6'd0;
      exp_q.push_back(bt);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Sink readiness, changed just after each rising edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready = ready_rand ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // Reference model, compared on every clock away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(req_ready == (exp_q.size() == 0), "R2", "req_ready", 64'(req_ready),
          64'(exp_q.size() == 0));
      if (exp_q.size() == 0)
        chk(!m_tvalid, "R2", "tvalid while idle", 64'(m_tvalid), 64'd0);
      chk(req_err == err_due, "R8", "req_err", 64'(req_err), 64'(err_due));
      if (prev_stall) begin
        chk(m_tvalid, "R3", "tvalid held", 64'(m_tvalid), 64'd1);
        chk(m_tdata == prev_beat.data && m_tcrc == prev_beat.crc &&
            m_tlast == prev_beat.last && m_mty == prev_beat.mty,
            "R3", "beat held", 64'(m_tdata), 64'(prev_beat.data));
      end
      if (m_tvalid) begin
        chk(m_len == e_len && m_qid == e_qid && m_port == e_port &&
            m_cmpt == e_cmpt && m_marker == e_marker, "R4", "sideband",
            {29'd0, m_cmpt, m_marker, m_port, m_qid, m_len},
            {29'd0, e_cmpt, e_marker, e_port, e_qid, e_len});
        chk(m_ecc == e_ecc, "R9", "ecc", 64'(m_ecc), 64'(e_ecc));
      end
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected beat", 64'd1, 64'd0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(m_tdata == e.data, (e_len == 0) ? "R5" : "R10", "data",
              64'(m_tdata), 64'(e.data));
          chk(m_tcrc == e.crc, (e_len == 0) ? "R5" : "R7", "crc",
              64'(m_tcrc), 64'(e.crc));
          chk(m_tlast == e.last, "R1", "last", 64'(m_tlast), 64'(e.last));
          chk(m_mty == e.mty, "R6", "mty", 64'(m_mty), 64'(e.mty));
        end
      end
      prev_stall = m_tvalid && !m_tready;
      prev_beat  = {m_tdata, m_tcrc, m_tlast, m_mty};
      err_due    = 1'b0;
      if (req_valid && req_ready) begin
        if (int'(req_len) > LIMIT) begin
          err_due = 1'b1;
        end else begin
          cur_pkt++;
          e_len = req_len; e_qid = req_qid; e_port = req_port;
          e_cmpt = req_cmpt; e_marker = req_marker;
          e_ecc = ecc_ref({24'h0, req_cmpt, req_marker, req_port, req_qid, req_len});
          push_pkt(int'(req_len));
        end
      end
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
        finish_run();
      end
    end
  end

  task automatic send(input int len, input int qid, input int port,
                      input bit cmpt, input bit mk);
    @(posedge clk); #1;
    req_valid = 1'b1; req_len = 16'(len); req_qid = 12'(qid);
    req_port = 3'(port); req_cmpt = cmpt; req_marker = mk;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || m_tvalid || !req_ready);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    req_valid = 0; req_len = 0; req_qid = 0; req_port = 0;
    req_cmpt = 0; req_marker = 0; m_tready = 1;
    repeat (3) @(negedge clk);
    chk(!m_tvalid, "R2", "reset tvalid", 64'(m_tvalid), 64'd0);
    chk(req_ready, "R2", "reset req_ready", 64'(req_ready), 64'd1);
    chk(!req_err, "R8", "reset req_err", 64'(req_err), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // Full-rate sink: single, partial, empty and multi-beat packets.
    send(8, 12'h001, 0, 1, 0);
    send(1, 12'hABC, 5, 0, 1);
    send(13, 12'h7FF, 7, 1, 1);
    send(0, 12'h123, 2, 0, 0);
    send(64, 12'hFFF, 3, 1, 0);
    send(27, 12'h0F0, 6, 0, 1);
    wait_idle();

    // Stalling sink, back-to-back requests.
    ready_rand = 1;
    send(100, 12'h456, 1, 1, 1);
    send(0, 12'h800, 4, 1, 1);
    send(16, 12'h321, 0, 0, 0);
    send(7, 12'h654, 2, 1, 0);
    send(LIMIT + 1, 12'h111, 1, 0, 0);
    send(33, 12'h222, 5, 0, 1);
    wait_idle();

    // Length limit edges.
    send(LIMIT, 12'h999, 7, 1, 1);
    send(LIMIT + 1, 12'h998, 6, 0, 1);
    send(65535, 12'h997, 5, 1, 0);
    send(0, 12'h996, 4, 0, 0);
    ready_rand = 0;
    send(LIMIT - 3, 12'h995, 3, 1, 1);
    wait_idle();

    finish_run();
  end

endmodule